// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the start-up command sequence of an SDR SDRAM once the supply and clock have settled. It waits for a power-stable indication. It then issues one precharge of all banks and two auto-refresh commands, and finally loads the mode register. Between the commands it holds the command pins at NOP for a fixed number of clock cycles. After the last wait it raises a ready flag, which lets the rest of the memory controller take over the bus.

Each wait is set at elaboration. The bench divides a nanosecond timing by the clock period, rounds down, and keeps at least one cycle. The mode word is built from four selectable fields: burst length, burst type, CAS latency and write burst mode. The block does not handle the long stabilisation delay before start, ordinary reads and writes, or refresh scheduling.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset (rstN low, asynchronous) is asserted, the command pins {csN, rasN, casN, weN} read NOP = 0111, addr and bank are zero and ready is low.
- R2: Out of reset the block stays idle and outputs NOP with powerStable low. The first rising edge that samples powerStable high moves it on, and the cycle after that edge carries the precharge command.
- R3: The precharge command is 0010 and lasts exactly one cycle. During that cycle addr bit 10 is 1, every other addr bit is 0 and bank is 0, so all banks are precharged.
- R4: Exactly two auto-refresh commands (0001) are issued, each lasting one cycle, with addr and bank zero.
- R5: The load-mode command is 0000 with bank zero. The mode word is on addr as follows: [2:0] burst length (1=000, 2=001, 4=010, 8=011), [3] burst type (sequential=0, interleaved=1), [6:4] CAS latency (2=010, 3=011), [8:7] operating mode 00, [9] write burst mode (programmed length=0, single access=1), [11:10] zero. The default configuration (length 4, sequential, latency 3, programmed length) gives 0x032.
- R6: Each command is followed by NOP cycles before the next step. After precharge there are floor(tRP/tCK) of them, after each refresh floor(tRFC/tCK), and after the mode load floor(tMRD/tCK). Each count is at least 1. With the defaults (tCK 12 ns, tRP 15, tRFC 66, tMRD 24) the counts are 1, 5 and 5, and 2.
- R7: ready rises in the cycle after the last mode-load wait cycle. It then stays high until reset, and the command pins stay NOP.
- R8: Once the block has left idle, powerStable has no effect. Toggling it or holding it high neither restarts nor changes the sequence.
- R9: Asserting reset at any point, including mid-sequence or after ready, returns the block to idle. A new sequence then starts from precharge.
- R10: The wait counts and the mode word follow the parameters. With tCK 10 ns, burst length 8, interleaved bursts, CAS latency 2 and single-access writes, the waits are 1, 6, 6 and 2 and the mode word is 0x22B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerStable | input | 1 | Start indication, sampled only while idle |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | ADDR_W (12) | SDRAM address bus |
| bank | output | BANK_W (2) | SDRAM bank address |
| ready | output | 1 | Initialization complete, sticky until reset |

## Verification
The properties assume that reset is the only way back to idle, and that powerStable may take any value on any cycle. None of them depends on the start input being quiet once the sequence runs. The stimulus therefore drives powerStable randomly on every cycle, both during the sequence and after ready. It also pulls reset at random points to restart the sequence. It always drives both inputs just after a falling edge, so they are stable at every rising edge. Two instances with different periods and mode fields run side by side to cover the parameter-dependent waits and mode-word layout.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE      = 4'd0,
    ST_PRE       = 4'd1,
    ST_WAIT_RP   = 4'd2,
    ST_REF1      = 4'd3,
    ST_WAIT_RFC1 = 4'd4,
    ST_REF2      = 4'd5,
    ST_WAIT_RFC2 = 4'd6,
    ST_LMR       = 4'd7,
    ST_WAIT_MRD  = 4'd8,
    ST_READY     = 4'd9
  } initState_e;

  typedef enum logic [1:0] {
    WAIT_RP  = 2'd0,
    WAIT_RFC = 2'd1,
    WAIT_MRD = 2'd2
  } waitSel_e;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_NOP       = 4'b0111;
  localparam logic [3:0] CMD_PRECHARGE = 4'b0010;
  localparam logic [3:0] CMD_REFRESH   = 4'b0001;
  localparam logic [3:0] CMD_LOAD_MODE = 4'b0000;

  typedef struct packed {
    logic     issuePre;
    logic     issueRefresh;
    logic     issueLoadMode;
    logic     loadWait;
    waitSel_e waitSel;
    logic     initDone;
  } seqStrobe_t;

  function automatic int waitCycles(input int timeNs, input int periodNs);
    int q;
    q = timeNs / periodNs;
    return (q < 1) ? 1 : q;
  endfunction

  function automatic logic [2:0] burstLenCode(input int len);
    case (len)
      1:       return 3'b000;
      2:       return 3'b001;
      8:       return 3'b011;
      default: return 3'b010;
    endcase
  endfunction

  function automatic logic [2:0] casLatCode(input int lat);
    case (lat)
      3:       return 3'b011;
      default: return 3'b010;
    endcase
  endfunction

  function automatic logic [9:0] modeLow(input int len, input int lat,
                                         input bit interleaved, input bit singleWr);
    return {singleWr, 2'b00, casLatCode(lat), interleaved, burstLenCode(len)};
  endfunction

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerStable,
  input  logic       waitDone,
  output seqStrobe_t strobe
);

  initState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:      if (powerStable) nextState = ST_PRE;
      ST_PRE:       nextState = ST_WAIT_RP;
      ST_WAIT_RP:   if (waitDone) nextState = ST_REF1;
      ST_REF1:      nextState = ST_WAIT_RFC1;
      ST_WAIT_RFC1: if (waitDone) nextState = ST_REF2;
      ST_REF2:      nextState = ST_WAIT_RFC2;
      ST_WAIT_RFC2: if (waitDone) nextState = ST_LMR;
      ST_LMR:       nextState = ST_WAIT_MRD;
      ST_WAIT_MRD:  if (waitDone) nextState = ST_READY;
      ST_READY:     nextState = ST_READY;
      default:      nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe = '{issuePre: 1'b0, issueRefresh: 1'b0, issueLoadMode: 1'b0,
               loadWait: 1'b0, waitSel: WAIT_RP, initDone: 1'b0};
    case (state)
      ST_PRE: begin
        strobe.issuePre = 1'b1;
        strobe.loadWait = 1'b1;
        strobe.waitSel  = WAIT_RP;
      end
      ST_REF1, ST_REF2: begin
        strobe.issueRefresh = 1'b1;
        strobe.loadWait     = 1'b1;
        strobe.waitSel      = WAIT_RFC;
      end
      ST_LMR: begin
        strobe.issueLoadMode = 1'b1;
        strobe.loadWait      = 1'b1;
        strobe.waitSel       = WAIT_MRD;
      end
      ST_READY: strobe.initDone = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/sdram_init_datapath.sv
module sdram_init_datapath
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BANK_W      = 2,
  parameter int RP_CYC      = 1,
  parameter int RFC_CYC     = 5,
  parameter int MRD_CYC     = 2,
  parameter int PRE_ALL_BIT = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  output logic              waitDone,
  output logic [3:0]        cmdPins,
  output logic [ADDR_W-1:0] addrOut,
  output logic [BANK_W-1:0] bankOut,
  output logic              readyOut
);

  localparam int MAX_CYC = (RFC_CYC > RP_CYC)
                         ? ((RFC_CYC > MRD_CYC) ? RFC_CYC : MRD_CYC)
                         : ((RP_CYC  > MRD_CYC) ? RP_CYC  : MRD_CYC);
  localparam int CNT_W = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    case (strobe.waitSel)
      WAIT_RFC: loadVal = CNT_W'(RFC_CYC - 1);
      WAIT_MRD: loadVal = CNT_W'(MRD_CYC - 1);
      default:  loadVal = CNT_W'(RP_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 waitCnt <= '0;
    else if (strobe.loadWait)  waitCnt <= loadVal;
    else if (waitCnt != '0)    waitCnt <= waitCnt - 1'b1;
  end

  assign waitDone = (waitCnt == '0);

  always_comb begin
    if (strobe.issuePre)           cmdPins = CMD_PRECHARGE;
    else if (strobe.issueRefresh)  cmdPins = CMD_REFRESH;
    else if (strobe.issueLoadMode) cmdPins = CMD_LOAD_MODE;
    else                           cmdPins = CMD_NOP;
  end

  for (genvar i = 0; i < ADDR_W; i++) begin : g_addr
    if (i == PRE_ALL_BIT) begin : g_all
      assign addrOut[i] = strobe.issuePre | (strobe.issueLoadMode & MODE_WORD[i]);
    end else begin : g_mode
      assign addrOut[i] = strobe.issueLoadMode & MODE_WORD[i];
    end
  end

  assign bankOut  = '0;
  assign readyOut = strobe.initDone;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_PERIOD_NS     = 12,
  parameter int T_RP_NS           = 15,
  parameter int T_RFC_NS          = 66,
  parameter int T_MRD_NS          = 24,
  parameter int BURST_LEN         = 4,
  parameter int CAS_LATENCY       = 3,
  parameter bit BURST_INTERLEAVED = 1'b0,
  parameter bit WRITE_SINGLE      = 1'b0,
  parameter int ADDR_W            = 12,
  parameter int BANK_W            = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerStable,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              ready
);

  localparam int RP_CYC  = waitCycles(T_RP_NS,  CLK_PERIOD_NS);
  localparam int RFC_CYC = waitCycles(T_RFC_NS, CLK_PERIOD_NS);
  localparam int MRD_CYC = waitCycles(T_MRD_NS, CLK_PERIOD_NS);
  localparam logic [ADDR_W-1:0] MODE_WORD =
    ADDR_W'(modeLow(BURST_LEN, CAS_LATENCY, BURST_INTERLEAVED, WRITE_SINGLE));

  seqStrobe_t strobe;
  logic       waitDone;
  logic [3:0] cmdPins;

  sdram_init_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .powerStable(powerStable),
    .waitDone   (waitDone),
    .strobe     (strobe)
  );

  sdram_init_datapath #(
    .ADDR_W     (ADDR_W),
    .BANK_W     (BANK_W),
    .RP_CYC     (RP_CYC),
    .RFC_CYC    (RFC_CYC),
    .MRD_CYC    (MRD_CYC),
    .PRE_ALL_BIT(10),
    .MODE_WORD  (MODE_WORD)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .waitDone(waitDone),
    .cmdPins (cmdPins),
    .addrOut (addr),
    .bankOut (bank),
    .readyOut(ready)
  );

  assign {csN, rasN, casN, weN} = cmdPins;

endmodule

// File: rtl/sdram_init_seq_checker.sv
module sdram_init_seq_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic              ready
);

  p_ready_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> cmd == 4'b0111);

  p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  p_cmd_one_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd != 4'b0111) |=> (cmd == 4'b0111));

  p_pre_all_banks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 4'b0010) |-> addr[10]);

  p_refresh_addr_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 4'b0001) |-> (addr == '0));

  p_cmd_legal_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmd inside {4'b0111, 4'b0010, 4'b0001, 4'b0000});

endmodule

bind sdram_init_seq sdram_init_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk  (clk),
  .rstN (rstN),
  .cmd  ({csN, rasN, casN, weN}),
  .addr (addr),
  .ready(ready)
);

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/1ps
module sdram_init_seq_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerStable = 1'b0;
  always #10 clk = ~clk;

  logic        csA, rasA, casA, weA, readyA;
  logic [11:0] addrA;
  logic [1:0]  bankA;
  logic        csB, rasB, casB, weB, readyB;
  logic [11:0] addrB;
  logic [1:0]  bankB;

  sdram_init_seq u_sdram_init_seq (
    .clk(clk), .rstN(rstN), .powerStable(powerStable),
    .csN(csA), .rasN(rasA), .casN(casA), .weN(weA),
    .addr(addrA), .bank(bankA), .ready(readyA)
  );

  sdram_init_seq #(
    .CLK_PERIOD_NS(10), .BURST_LEN(8), .CAS_LATENCY(2),
    .BURST_INTERLEAVED(1'b1), .WRITE_SINGLE(1'b1)
  ) u_sdram_init_seq_alt (
    .clk(clk), .rstN(rstN), .powerStable(powerStable),
    .csN(csB), .rasN(rasB), .casN(casB), .weN(weB),
    .addr(addrB), .bank(bankB), .ready(readyB)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int phA = 0;
  int phB = 0;

  function automatic int expWait(input int ns, input int tck);
    return (ns / tck < 1) ? 1 : ns / tck;
  endfunction

  // waits per instance: A (12 ns) and B (10 ns)
  int rpA, rfcA, mrdA, rpB, rfcB, mrdB;
  initial begin
    rpA = expWait(15, 12); rfcA = expWait(66, 12); mrdA = expWait(24, 12);
    rpB = expWait(15, 10); rfcB = expWait(66, 10); mrdB = expWait(24, 10);
  end

  function automatic int readyPh(input int rp, input int rfc, input int mrd);
    return 2 + rp + 1 + rfc + 1 + rfc + 1 + mrd;
  endfunction

  // {ready, cmd[3:0], bank[1:0], addr[11:0]}
  function automatic logic [18:0] expOut(input int ph, input int rp, input int rfc,
                                          input int mrd, input logic [11:0] mw);
    int a1, a2, lm;
    a1 = 2 + rp; a2 = a1 + 1 + rfc; lm = a2 + 1 + rfc;
    if (ph == 1)                    return {1'b0, 4'b0010, 2'b00, 12'h400};
    if (ph == a1 || ph == a2)       return {1'b0, 4'b0001, 2'b00, 12'h000};
    if (ph == lm)                   return {1'b0, 4'b0000, 2'b00, mw};
    if (ph >= readyPh(rp, rfc, mrd)) return {1'b1, 4'b0111, 2'b00, 12'h000};
    return {1'b0, 4'b0111, 2'b00, 12'h000};
  endfunction

  function automatic string phTag(input int ph, input int rp, input int rfc, input int mrd,
                                  input bit alt);
    int a1, a2, lm;
    a1 = 2 + rp; a2 = a1 + 1 + rfc; lm = a2 + 1 + rfc;
    if (ph == 0) return "R2";
    if (ph == 1) return "R3";
    if (ph == a1 || ph == a2) return "R4";
    if (ph == lm) return alt ? "R10" : "R5";
    if (ph >= readyPh(rp, rfc, mrd)) return "R7";
    return alt ? "R10" : "R6";
  endfunction

  function automatic int advance(input int ph, input logic st, input logic rs, input int rd);
    if (!rs) return 0;
    if (ph == 0) return st ? 1 : 0;
    if (ph < rd) return ph + 1;
    return ph;
  endfunction

  task automatic checkOne(input string tag, input string name,
                          input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got ready=%b cmd=%b bank=%b addr=%h, expected ready=%b cmd=%b bank=%b addr=%h",
               tag, name, act[18], act[17:14], act[13:12], act[11:0],
               exp[18], exp[17:14], exp[13:12], exp[11:0]);
    end
  endtask

  task automatic checkBoth(input string forced, input bit busyStart);
    string tA, tB;
    tA = (forced != "") ? forced : phTag(phA, rpA, rfcA, mrdA, 1'b0);
    tB = (forced != "") ? forced : phTag(phB, rpB, rfcB, mrdB, 1'b1);
    if (busyStart) begin
      tA = {tA, " R8"};
      tB = {tB, " R8"};
    end
    checkOne(tA, "default", {readyA, csA, rasA, casA, weA, bankA, addrA},
             expOut(phA, rpA, rfcA, mrdA, 12'h032));
    checkOne(tB, "alt",     {readyB, csB, rasB, casB, weB, bankB, addrB},
             expOut(phB, rpB, rfcB, mrdB, 12'h22B));
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic tick(input logic st, input logic rs);
    bit busy;
    powerStable = st;
    rstN = rs;
    @(posedge clk);
    busy = st && rs && (phA > 0);
    phA = advance(phA, st, rs, readyPh(rpA, rfcA, mrdA));
    phB = advance(phB, st, rs, readyPh(rpB, rfcB, mrdB));
    @(negedge clk);
    checkBoth(rs ? "" : "R9", busy);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(64'd20 * 64'd150000);
    errors++;
    checks++;
    $display("FAIL watchdog: got no completion, expected completion within limit");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: outputs during reset
    repeat (2) @(negedge clk);
    checkBoth("R1", 1'b0);
    tick(1'b1, 1'b0);                   // start high still ignored in reset: R1
    // R2: idle with start low
    repeat (5) tick(1'b0, 1'b1);
    // single-cycle start pulse, run to ready and beyond (R3-R7, R10)
    tick(1'b1, 1'b1);
    repeat (30) tick(1'b0, 1'b1);
    // R8: start toggling after ready
    for (int i = 0; i < 8; i++) tick(i[0], 1'b1);
    // R9: reset after ready
    tick(1'b0, 1'b0);
    // start held high continuously (R8) then reset mid-refresh wait (R9)
    repeat (7) tick(1'b1, 1'b1);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b1);
    // R8: start held high for the whole sequence
    repeat (32) tick(1'b1, 1'b1);
    tick(1'b0, 1'b0);
    // random runs
    for (int it = 0; it < 40; it++) begin
      int idle, abortAt, cyc;
      idle = $urandom % 6;
      abortAt = (($urandom % 4) == 0) ? int'($urandom % 22) + 1 : -1;
      repeat (idle) tick(1'b0, 1'b1);
      tick(1'b1, 1'b1);
      cyc = 0;
      while (cyc < 30) begin
        cyc++;
        if (cyc == abortAt) tick(logic'($urandom % 2), 1'b0);
        else                tick(logic'($urandom % 2), 1'b1);
      end
      tick(1'b0, 1'b0);
    end
    finishRun();
  end

endmodule